// File: doc/BRIEF.md
# Per-Pin Configurable Multi-Source I/O Port

This block is a processor-facing general-purpose port whose pins can each do a different job at the same moment. Every pin has its own 2-bit source select. The select picks what the pin drives: a processor-written data bit, one bit of a multiplexed address bus, the output of a programmable logic cell, or a chip-select line. The address bit comes from a transparent latch. The latch follows the address while the address-latch-enable input is high and holds its value once that input falls, so a port pin can carry a demultiplexed low address.

The configuration sits behind a small register bus with a 3-bit offset, a write strobe and a read strobe. It holds a data-out register, a direction register and a source-select vector. A read-back multiplexer returns exactly one source per read. The source can be the raw pad inputs, one of the registers, or the logic-cell outputs. The read result is registered. The pad is modelled as separate output, output-enable and input vectors. The width is set by `WIDTH`: 8 by default, and down to 3 for a narrow port.

Top module: `cfg_io_port`

## Requirements
- R1: While and after reset, the data-out, direction and select registers, the address latch and `rd_data` are all zero. Every pin therefore selects data-out, with `pad_oe` low and `pad_out` low.
- R2: A write (`wr_en` high at a rising clock edge) loads `wr_data` at that edge. Offset 1 loads data-out, offset 2 loads direction, offset 3 loads select bits [WIDTH-1:0] and offset 4 loads select bits [2*WIDTH-1:WIDTH]. When `wr_en` is low, no register changes.
- R3: Pin i uses select bits [2i+1:2i]. Code 00 drives data-out bit i, 01 drives latched address bit i, 10 drives `mc_out[i]` and 11 drives `ext_cs[i]`. Each pin's choice is independent of the others.
- R4: The address latch is transparent while `ale` is high. While `ale` is low it holds its value, whatever `bus_addr` does.
- R5: `pad_oe[i]` equals `mc_oe[i]` when pin i selects code 10. For every other code it equals direction bit i.
- R6: When `rd_en` is high at a rising edge, `rd_data` after that edge holds the source at `reg_addr`. Offset 0 returns `pad_in`, 1 data-out, 2 direction, 3 the select low half, 4 the select high half, 5 `mc_out`, and 6 and 7 return zero.
- R7: When `rd_en` is low at an edge, `rd_data` keeps its value.
- R8: Writes to offsets 0, 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Registered read data |
| ale | input | 1 | Address latch enable |
| bus_addr | input | WIDTH | Multiplexed address bits |
| mc_out | input | WIDTH | Logic-cell outputs |
| mc_oe | input | WIDTH | Logic-cell output-enable product terms |
| ext_cs | input | WIDTH | Chip-select lines |
| pad_in | input | WIDTH | Pad input values |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |

## Verification
The select vector is first set uniform, with all pins on one code, so a wrong code decode shows up on every pin at once. It is then set to rotating patterns, where neighbouring pins use different codes; this catches swapped or misaligned select bit pairs and a wrong split between the low and high halves. The address latch is tried with `bus_addr` changing both while `ale` is high and while it is low, which separates a transparent latch from a flop or a plain wire. A long random mix of writes to every offset, reads of every offset and changing pad and logic-cell inputs, checked against a bench model, exposes read-back selection errors, ignored-offset writes that leak into a register, and output enables taken from the wrong source.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  typedef enum logic [1:0] {
    SRC_DATA  = 2'b00,
    SRC_ADDR  = 2'b01,
    SRC_MACRO = 2'b10,
    SRC_CS    = 2'b11
  } pin_src_e;

  localparam int unsigned OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_PIN    = 3'd0;
  localparam logic [OFS_W-1:0] OFS_DOUT   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_DIR    = 3'd2;
  localparam logic [OFS_W-1:0] OFS_SEL_LO = 3'd3;
  localparam logic [OFS_W-1:0] OFS_SEL_HI = 3'd4;
  localparam logic [OFS_W-1:0] OFS_MACRO  = 3'd5;
endpackage

// File: rtl/io_cfg_regs.sv
module io_cfg_regs
  import io_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     reg_addr,
  input  logic [WIDTH-1:0]     wr_data,
  output logic [WIDTH-1:0]     dout_q,
  output logic [WIDTH-1:0]     dir_q,
  output logic [2*WIDTH-1:0]   sel_q
);
  localparam int unsigned SEL_W = 2 * WIDTH;

  logic             dout_en, dir_en, sel_lo_en, sel_hi_en;
  logic [SEL_W-1:0] sel_d;

  // decoded clock enables
  always_comb begin
    dout_en   = wr_en && (reg_addr == OFS_DOUT);
    dir_en    = wr_en && (reg_addr == OFS_DIR);
    sel_lo_en = wr_en && (reg_addr == OFS_SEL_LO);
    sel_hi_en = wr_en && (reg_addr == OFS_SEL_HI);
  end

  always_comb begin
    sel_d = sel_q;
    if (sel_lo_en) sel_d[WIDTH-1:0]     = wr_data;
    if (sel_hi_en) sel_d[SEL_W-1:WIDTH] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_lo_en || sel_hi_en) begin
      sel_q <= sel_d;
    end
  end

  // R2: a data-out write lands on the strobe edge
  p_dout_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == OFS_DOUT) |=> (dout_q == $past(wr_data)));

  // R2: no strobe, no change
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dout_q) && $stable(dir_q) && $stable(sel_q)));

  // R8: read-only and unused offsets leave the registers alone
  p_ro_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (reg_addr == OFS_PIN || reg_addr == OFS_MACRO || reg_addr > OFS_MACRO))
    |=> ($stable(dout_q) && $stable(dir_q) && $stable(sel_q)));
endmodule

// File: rtl/io_addr_latch.sv
module io_addr_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic [WIDTH-1:0] bus_addr,
  output logic [WIDTH-1:0] addr_q
);
  always_latch begin
    if (!rst_n) begin
      addr_q = '0;
    end else if (ale) begin
      addr_q = bus_addr;
    end
  end

  // R4: with ale low across a whole cycle the latch holds
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale)) |-> $stable(addr_q));
endmodule

// File: rtl/io_pin_mux.sv
module io_pin_mux
  import io_port_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       dout_bit,
  input  logic       addr_bit,
  input  logic       mc_bit,
  input  logic       cs_bit,
  input  logic       dir_bit,
  input  logic       mc_oe_bit,
  output logic       out,
  output logic       oe
);
  pin_src_e src;

  always_comb begin
    src = pin_src_e'(sel);
    unique case (src)
      SRC_DATA:  out = dout_bit;
      SRC_ADDR:  out = addr_bit;
      SRC_MACRO: out = mc_bit;
      SRC_CS:    out = cs_bit;
      default:   out = dout_bit;
    endcase
    oe = (src == SRC_MACRO) ? mc_oe_bit : dir_bit;
  end
endmodule

// File: rtl/io_readback.sv
module io_readback
  import io_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [OFS_W-1:0]   reg_addr,
  input  logic [WIDTH-1:0]   pad_in,
  input  logic [WIDTH-1:0]   dout_q,
  input  logic [WIDTH-1:0]   dir_q,
  input  logic [2*WIDTH-1:0] sel_q,
  input  logic [WIDTH-1:0]   mc_out,
  output logic [WIDTH-1:0]   rd_data
);
  logic [WIDTH-1:0] rd_d;

  always_comb begin
    unique case (reg_addr)
      OFS_PIN:    rd_d = pad_in;
      OFS_DOUT:   rd_d = dout_q;
      OFS_DIR:    rd_d = dir_q;
      OFS_SEL_LO: rd_d = sel_q[WIDTH-1:0];
      OFS_SEL_HI: rd_d = sel_q[2*WIDTH-1:WIDTH];
      OFS_MACRO:  rd_d = mc_out;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end

  // R7: read data holds between strobes
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R6: a data-out read returns the register as it stood at the strobe
  p_rd_dout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == OFS_DOUT) |=> (rd_data == $past(dout_q)));
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import io_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFS_W-1:0]   reg_addr,
  input  logic               wr_en,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               rd_en,
  output logic [WIDTH-1:0]   rd_data,
  input  logic               ale,
  input  logic [WIDTH-1:0]   bus_addr,
  input  logic [WIDTH-1:0]   mc_out,
  input  logic [WIDTH-1:0]   mc_oe,
  input  logic [WIDTH-1:0]   ext_cs,
  input  logic [WIDTH-1:0]   pad_in,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_oe
);
  localparam int unsigned SEL_W = 2 * WIDTH;

  logic [WIDTH-1:0] dout_q, dir_q, addr_q;
  logic [SEL_W-1:0] sel_q;

  io_cfg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .dout_q   (dout_q),
    .dir_q    (dir_q),
    .sel_q    (sel_q)
  );

  io_addr_latch #(.WIDTH(WIDTH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .bus_addr (bus_addr),
    .addr_q   (addr_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    io_pin_mux u_mux (
      .sel       (sel_q[2*i+1:2*i]),
      .dout_bit  (dout_q[i]),
      .addr_bit  (addr_q[i]),
      .mc_bit    (mc_out[i]),
      .cs_bit    (ext_cs[i]),
      .dir_bit   (dir_q[i]),
      .mc_oe_bit (mc_oe[i]),
      .out       (pad_out[i]),
      .oe        (pad_oe[i])
    );
  end

  io_readback #(.WIDTH(WIDTH)) u_rdbk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .reg_addr (reg_addr),
    .pad_in   (pad_in),
    .dout_q   (dout_q),
    .dir_q    (dir_q),
    .sel_q    (sel_q),
    .mc_out   (mc_out),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/tb_cfg_io_port.sv
`timescale 1ns/1ps
module tb_cfg_io_port;
  localparam int W = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [2:0]   reg_addr = '0;
  logic         wr_en = 0, rd_en = 0, ale = 0;
  logic [W-1:0] wr_data = '0, bus_addr = '0, mc_out = '0, mc_oe = '0, ext_cs = '0, pad_in = '0;
  logic [W-1:0] rd_data, pad_out, pad_oe;

  logic [W-1:0]   m_dout = '0, m_dir = '0, m_lat = '0;
  logic [2*W-1:0] m_sel = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_io_port #(.WIDTH(W)) dut (.*);

  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      case (m_sel[2*i +: 2])
        2'b00: r[i] = m_dout[i];
        2'b01: r[i] = m_lat[i];
        2'b10: r[i] = mc_out[i];
        default: r[i] = ext_cs[i];
      endcase
    return r;
  endfunction

  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = (m_sel[2*i +: 2] == 2'b10) ? mc_oe[i] : m_dir[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [2:0] off);
    case (off)
      3'd0: return pad_in;
      3'd1: return m_dout;
      3'd2: return m_dir;
      3'd3: return m_sel[W-1:0];
      3'd4: return m_sel[2*W-1:W];
      3'd5: return mc_out;
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pads(input string req);
    check(pad_out == exp_out(), {req, " pad_out"}, 32'(pad_out), 32'(exp_out()));
    check(pad_oe == exp_oe(), {req, " pad_oe R5"}, 32'(pad_oe), 32'(exp_oe()));
  endtask

  task automatic do_write(input logic [2:0] off, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; reg_addr = off; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    case (off)
      3'd1: m_dout = d;
      3'd2: m_dir = d;
      3'd3: m_sel[W-1:0] = d;
      3'd4: m_sel[2*W-1:W] = d;
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [2:0] off, input string req);
    logic [W-1:0] e;
    @(negedge clk);
    rd_en = 1; reg_addr = off;
    e = exp_rd(off);
    @(posedge clk); #1;
    rd_en = 0;
    check(rd_data == e, req, 32'(rd_data), 32'(e));
  endtask

  task automatic set_sel(input logic [2*W-1:0] s);
    do_write(3'd3, s[W-1:0]);
    do_write(3'd4, s[2*W-1:W]);
  endtask

  task automatic drive_in(input logic a, input logic [W-1:0] ba);
    @(negedge clk);
    ale = a; bus_addr = ba;
    mc_out = W'($urandom); mc_oe = W'($urandom);
    ext_cs = W'($urandom); pad_in = W'($urandom);
    if (a) m_lat = ba;
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h5EED_1234));
    mc_out = 8'hA5; mc_oe = 8'h3C; ext_cs = 8'h0F;
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset
    check(pad_oe == '0 && pad_out == '0, "R1 pads in reset", {pad_oe, pad_out}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(rd_data == '0, "R1 rd_data after reset", 32'(rd_data), 0);
    check_pads("R1");
    do_read(3'd3, "R1 sel low zero");
    do_read(3'd2, "R1 dir zero");

    // R2/R3: uniform codes on all pins
    do_write(3'd1, 8'h5A);
    do_write(3'd2, 8'hC3);
    drive_in(1, 8'h96);
    for (int c = 0; c < 4; c++) begin
      set_sel({W{2'(c)}});
      drive_in(0, W'($urandom));
      check_pads("R3 uniform code");
    end
    // R3: rotating codes across pins
    for (int k = 0; k < 4; k++) begin
      logic [2*W-1:0] s;
      for (int i = 0; i < W; i++) s[2*i +: 2] = 2'((i + k) % 4);
      set_sel(s);
      drive_in(0, W'($urandom));
      check_pads("R3 mixed codes");
      do_read(3'd3, "R6 sel low");
      do_read(3'd4, "R6 sel high");
    end

    // R4: latch transparency and hold
    set_sel({W{2'b01}});
    drive_in(1, 8'h3E);
    check(pad_out == 8'h3E, "R4 transparent", 32'(pad_out), 32'h3E);
    drive_in(1, 8'hC1);
    check(pad_out == 8'hC1, "R4 follows", 32'(pad_out), 32'hC1);
    drive_in(0, 8'h77);
    check(pad_out == 8'hC1, "R4 hold", 32'(pad_out), 32'hC1);
    repeat (3) drive_in(0, W'($urandom));
    check(pad_out == 8'hC1, "R4 hold long", 32'(pad_out), 32'hC1);

    // R8: writes to read-only / unused offsets
    do_write(3'd0, 8'hFF); do_write(3'd5, 8'hFF);
    do_write(3'd6, 8'hFF); do_write(3'd7, 8'hFF);
    for (int o = 1; o < 5; o++) do_read(3'(o), "R8 ignored write");
    check_pads("R8");

    // R7: read data holds while rd_en low
    do_read(3'd2, "R6 dir read");
    held = rd_data;
    do_write(3'd2, ~m_dir);
    repeat (3) drive_in(0, W'($urandom));
    check(rd_data == held, "R7 hold", 32'(rd_data), 32'(held));

    // every read-back source
    for (int o = 0; o < 8; o++) do_read(3'(o), "R6 offset sweep");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: do_write(3'($urandom_range(0, 7)), W'($urandom));
        1: do_read(3'($urandom_range(0, 7)), "R6 random read");
        default: drive_in(1'($urandom), W'($urandom));
      endcase
      check_pads("R2 R3 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule